// File: doc/BRIEF.md
# Per-Source DMA Request Generator

This block turns the completion of each trigger source's conversion chain into a DMA request line for that source. It serves eight trigger sources by default. When a source's chain reports completion and DMA is enabled for that source, the block sets a sticky status flag and raises the source's request line. The line is registered.

How a request is withdrawn depends on a request mode that is shared by all sources. In pulsed mode the DMA acknowledge alone withdraws the request. In latched mode the request stays up until two things have both happened: the acknowledge has arrived, and software has cleared the source's status flag. The acknowledge and the flag clear may come in either order, or in the same cycle.

A single 32-bit control word holds the state that software sees:

- The per-source enables are plain read/write bits, with source n at bit n.
- The mode is a read/write bit at bit 8. A value of 0 selects latched mode and 1 selects pulsed mode.
- The status flags sit at bits 23:16, with source n at bit 16+n. A flag clears when 1 is written to it.

Writing 0 to a status bit leaves it unchanged. Software can therefore read the word, change its enables, and write it back with the status field zeroed without losing any pending flag.

Top module: `dmarq_gen`

## Requirements
- R1: While reset is high and in the cycle after it, every request line is low and the control word reads 0 (enables 0, latched mode, no flags).
- R2: A write stores wr_data[NUM_SRC-1:0] as the enables and wr_data[8] as the mode (0 latched, 1 pulsed). All other bits, apart from the status field, read back as 0.
- R3: A cycle with chain_done[n] high while enable bit n is 1 sets status bit 16+n and dma_req[n] at the next clock edge. When enable bit n is 0, the same pulse changes neither of them.
- R4: Status bits 23:16 clear only when 1 is written to them. A write with 0 in a status bit leaves that flag as it was, whatever the write does to the enables or the mode.
- R5: If chain_done[n] sets a flag in the same cycle that a write-one clear targets that flag, the flag ends up set.
- R6: In pulsed mode, dma_ack[n] high while dma_req[n] is high, with no new completion from that source, drops dma_req[n] at the next edge. Status bit 16+n is left set.
- R7: In latched mode, dma_req[n] stays high after dma_ack[n] for as long as status bit 16+n is set. It drops at the edge where the flag is cleared, provided the acknowledge has come in that cycle or earlier. Clearing the flag without an acknowledge also leaves the request high.
- R8: dma_ack[n] on a source whose request is low has no effect. A completion in the same cycle as an acknowledge leaves the request high.
- R9: Each source's flag and request are affected only by that source's own completion, acknowledge and status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_done | input | NUM_SRC | One-cycle completion pulse per source |
| dma_ack | input | NUM_SRC | DMA acknowledge per source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read value |
| dma_req | output | NUM_SRC | Registered DMA request per source |

## Verification
A wrong internal state in this block has two visible symptoms. A request line may be stuck high after its acknowledge, or it may fall before the flag clears in latched mode. Both show on dma_req one cycle after the acknowledge or clear that should have decided the outcome. A lost or spurious flag shows in rd_data bits 23:16 in the very next cycle. The bench exercises every source in both modes, in both orders of acknowledge and flag clear. It also covers the set-versus-clear collision and read-modify-write preservation, so a fault in any one slot appears within a cycle of the stimulus that reaches it.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  localparam int WORD_W  = 32;
  localparam int MODE_B  = 8;
  localparam int STAT_LO = 16;

  typedef enum logic {
    MODE_LATCHED = 1'b0,
    MODE_PULSED  = 1'b1
  } dmarq_mode_e;
endpackage

// File: rtl/dmarq_ctrl_regs.sv
module dmarq_ctrl_regs
  import dmarq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_en_field,
  input  logic               wr_mode_bit,
  input  logic [NUM_SRC-1:0] wr_stat_field,
  output logic [NUM_SRC-1:0] en_q,
  output dmarq_mode_e        mode_q,
  output logic [NUM_SRC-1:0] clr_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= MODE_LATCHED;
    end else if (wr_en) begin
      en_q   <= wr_en_field;
      mode_q <= dmarq_mode_e'(wr_mode_bit);
    end
  end

  assign clr_pulse = wr_stat_field & {NUM_SRC{wr_en}};
endmodule

// File: rtl/dmarq_src_slot.sv
module dmarq_src_slot
  import dmarq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dmarq_mode_e mode,
  input  logic        enable,
  input  logic        done,
  input  logic        clr,
  input  logic        ack,
  output logic        flag_q,
  output logic        req_q
);
  logic set;
  logic flag_d;
  logic ack_seen_q;
  logic ack_any;

  assign set     = done & enable;
  assign flag_d  = set | (flag_q & ~clr);
  assign ack_any = ack | ack_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q     <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (set) begin
        req_q      <= 1'b1;
        ack_seen_q <= 1'b0;
      end else if (req_q) begin
        if (mode == MODE_PULSED) begin
          if (ack) req_q <= 1'b0;
          ack_seen_q <= 1'b0;
        end else if (ack_any && !flag_d) begin
          req_q      <= 1'b0;
          ack_seen_q <= 1'b0;
        end else begin
          ack_seen_q <= ack_any;
        end
      end else begin
        ack_seen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmarq_readback.sv
module dmarq_readback
  import dmarq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] en,
  input  dmarq_mode_e        mode,
  input  logic [NUM_SRC-1:0] flags,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word = '0;
    word[NUM_SRC-1:0]          = en;
    word[MODE_B]               = mode;
    word[STAT_LO +: NUM_SRC]   = flags;
  end
endmodule

// File: rtl/dmarq_gen.sv
module dmarq_gen
  import dmarq_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] chain_done,
  input  logic [NUM_SRC-1:0] dma_ack,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [NUM_SRC-1:0] dma_req
);
  logic [NUM_SRC-1:0] en_q;
  dmarq_mode_e        mode_q;
  logic [NUM_SRC-1:0] clr_pulse;
  logic [NUM_SRC-1:0] flags;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  dmarq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_en_field   (wr_data[NUM_SRC-1:0]),
    .wr_mode_bit   (wr_data[MODE_B]),
    .wr_stat_field (wr_data[STAT_LO +: NUM_SRC]),
    .en_q          (en_q),
    .mode_q        (mode_q),
    .clr_pulse     (clr_pulse)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    dmarq_src_slot u_slot (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode_q),
      .enable (en_q[g]),
      .done   (chain_done[g]),
      .clr    (clr_pulse[g]),
      .ack    (dma_ack[g]),
      .flag_q (flags[g]),
      .req_q  (dma_req[g])
    );
  end

  dmarq_readback #(.NUM_SRC(NUM_SRC)) u_rb (
    .en    (en_q),
    .mode  (mode_q),
    .flags (flags),
    .word  (rd_data)
  );
endmodule

// File: rtl/dmarq_gen_chk.sv
module dmarq_gen_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] chain_done,
  input logic [NUM_SRC-1:0] dma_ack,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic [NUM_SRC-1:0] dma_req
);
  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (dma_req == '0 && rd_data == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    p_set_on_done_r3: assert property (@(posedge clk) disable iff (rst)
      (chain_done[i] && rd_data[i]) |=> (dma_req[i] && rd_data[16+i]));

    p_rise_needs_done_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(dma_req[i]) |-> $past(chain_done[i] && rd_data[i]));

    p_rmw_keeps_flag_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_data[16+i] && !(wr_en && wr_data[16+i])) |=> rd_data[16+i]);

    p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (chain_done[i] && rd_data[i] && wr_en && wr_data[16+i]) |=> rd_data[16+i]);

    p_pulsed_ack_drops_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_data[8] && dma_req[i] && dma_ack[i] && !chain_done[i]) |=> !dma_req[i]);

    p_latched_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!rd_data[8] && dma_req[i] && rd_data[16+i] && !(wr_en && wr_data[16+i]))
      |=> dma_req[i]);
  end
endmodule

bind dmarq_gen dmarq_gen_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .chain_done (chain_done),
  .dma_ack    (dma_ack),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .dma_req    (dma_req)
);

// File: tb/test_dmarq_gen.sv
module test_dmarq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] chain_done = '0;
  logic [N-1:0] dma_ack = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  rd_data;
  logic [N-1:0] dma_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmarq_gen #(.NUM_SRC(N)) i_dmarq_gen (
    .clk(clk), .rst(rst), .chain_done(chain_done), .dma_ack(dma_ack),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .dma_req(dma_req)
  );

  function automatic logic [31:0] word(input logic [7:0] st, input logic md,
                                       input logic [7:0] en);
    return {8'h00, st, 7'h00, md, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    chain_done = '0;
    dma_ack    = '0;
    wr_en      = 1'b0;
    wr_data    = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 req", {24'h0, dma_req}, 32'h0);
    chk("R1 word", rd_data, 32'h0);
    rst = 1'b0;
    cyc();
    chk("R1 after", rd_data, 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R2 all ones", rd_data, word(8'h00, 1'b1, 8'hFF));
    wr(32'h0000_00A5);
    chk("R2 pattern", rd_data, word(8'h00, 1'b0, 8'hA5));

    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < N; s++) begin
        logic [7:0] b;
        b = 8'(1 << s);
        wr(word(8'h00, md[0], 8'hFF));
        chain_done = b; cyc();
        chk("R3 R9 req set", {24'h0, dma_req}, {24'h0, b});
        chk("R3 R9 flag set", rd_data, word(b, md[0], 8'hFF));
        if (md == 1) begin
          dma_ack = b; cyc();
          chk("R6 ack drops req", {24'h0, dma_req}, 32'h0);
          chk("R6 flag kept", rd_data, word(b, 1'b1, 8'hFF));
          wr(word(b, 1'b1, 8'hFF));
          chk("R4 w1c", rd_data, word(8'h00, 1'b1, 8'hFF));
        end else begin
          dma_ack = b; cyc();
          chk("R7 hold after ack", {24'h0, dma_req}, {24'h0, b});
          wr(word(b, 1'b0, 8'hFF));
          chk("R7 drop on clear", {24'h0, dma_req}, 32'h0);
          chk("R4 w1c", rd_data, word(8'h00, 1'b0, 8'hFF));
          chain_done = b; cyc();
          wr(word(b, 1'b0, 8'hFF));
          chk("R7 hold no ack", {24'h0, dma_req}, {24'h0, b});
          dma_ack = b; cyc();
          chk("R7 drop on late ack", {24'h0, dma_req}, 32'h0);
        end
        chain_done = b; wr_en = 1'b1; wr_data = word(b, md[0], 8'hFF); cyc();
        chk("R5 set wins", rd_data, word(b, md[0], 8'hFF));
        wr(word(b, 1'b1, 8'hFF));
        dma_ack = b; cyc();
        chk("R5 cleanup", {24'h0, dma_req}, 32'h0);
      end
    end

    wr(word(8'h00, 1'b1, 8'h0F));
    chain_done = 8'hFF; cyc();
    chk("R3 disabled sources", rd_data, word(8'h0F, 1'b1, 8'h0F));
    chk("R3 disabled req", {24'h0, dma_req}, 32'h0F);
    wr(word(8'h00, 1'b1, 8'hFF));
    chain_done = 8'hF0; cyc();
    wr(word(8'h00, 1'b1, 8'h3C));
    chk("R4 rmw keeps flags", rd_data, word(8'hFF, 1'b1, 8'h3C));

    wr(word(8'hFF, 1'b1, 8'hFF));
    dma_ack = 8'hFF; cyc();
    chk("R8 clean", {24'h0, dma_req}, 32'h0);
    dma_ack = 8'hFF; cyc();
    chk("R8 ack idle", {24'h0, dma_req}, 32'h0);
    chk("R8 ack idle flags", rd_data, word(8'h00, 1'b1, 8'hFF));
    chain_done = 8'h81; dma_ack = 8'h81; cyc();
    chk("R8 done beats ack", {24'h0, dma_req}, 32'h81);
    dma_ack = 8'h01; cyc();
    chk("R9 only own source", {24'h0, dma_req}, 32'h80);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule